// File: doc/BRIEF.md
# Noise Shift Register with Timed Clear

This block holds the 23-bit pseudo-random state behind a noise waveform. Each pulse on the shift strobe advances the register by one step. The oscillator sends this strobe a fixed delay after its bit-19 rising edge. Eight scattered register bits are gathered onto the top eight bits of a 12-bit noise word. The bottom four bits of that word are tied low.

Holding the test input high stops the register from advancing and starts a countdown. If test stays high long enough for the countdown to finish, the register is refilled with ones. When several waveforms are selected together, the combined 12-bit output can be written back into the eight tapped bits. This writeback can only clear bits. A noise combination therefore collapses toward zero after a few cycles.

Top module: `noise_lfsr_gen`

## Requirements
- R1: After rst_n is released, every one of the 23 register bits is 1 and noise_out reads 0xFF0.
- R2: When shift_stb is high and test is low, the register moves up by one bit. The new bit 0 is (bit 22 OR test) XOR bit 17.
- R3: While test is high, shift_stb has no effect on the register.
- R4: noise_out bits 11 down to 4 show register bits 20, 18, 14, 11, 9, 5, 2 and 0, in that order.
- R5: noise_out bits 3 to 0 are always 0.
- R6: When wb_en is high, each of the eight tapped register bits is ANDed with combo_in bits 11 down to 4, using the same pairing as R4. A bit cleared this way never returns to 1 through writeback.
- R7: When wb_en is low, combo_in has no effect on the register.
- R8: The clock edge where test is first seen high loads a countdown of RST_CYCLES. Each later edge with test high decrements it. The edge that takes it from 1 to 0 refills the register with all ones.
- R9: If test drops before the countdown expires, no refill happens, and the next rise of test reloads the full count.
- R10: A countdown refill wins over writeback and shift in the same cycle. When writeback and shift occur in the same cycle, the writeback is applied to the old state and the shift is applied to the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_stb | input | 1 | Advance the register by one step |
| test | input | 1 | Hold: blocks shifting and runs the refill countdown |
| wb_en | input | 1 | Combined-waveform writeback enable |
| combo_in | input | 12 | Combined waveform value used for writeback |
| noise_out | output | 12 | Noise waveform word |

## Verification
The hardest state to reach is a countdown that expires while the register is not already all ones. Without that, a refill cannot be seen at the output. The stimulus first drives the word to zero with a writeback of 0x000, then holds test. The output must stay 0x000 until the exact expiry edge and only then jump to 0xFF0. The same zeroed start is used to show that an interrupted hold reloads the full count, and that writeback in the expiry cycle loses to the refill.

// File: rtl/noise_lfsr_pkg.sv
package noise_lfsr_pkg;
  localparam int LFSR_W  = 23;
  localparam int WORD_W  = 12;
  localparam int NTAP    = 8;
  localparam int TAP_LSB = WORD_W - NTAP;
  localparam int FB_HI   = 22;
  localparam int FB_LO   = 17;

  typedef logic [LFSR_W-1:0] lfsr_t;
  typedef logic [WORD_W-1:0] word_t;

  // register bit feeding noise word bit TAP_LSB+i
  function automatic int tap_pos(input int i);
    case (i)
      0: tap_pos = 0;
      1: tap_pos = 2;
      2: tap_pos = 5;
      3: tap_pos = 9;
      4: tap_pos = 11;
      5: tap_pos = 14;
      6: tap_pos = 18;
      default: tap_pos = 20;
    endcase
  endfunction
endpackage

// File: rtl/noise_clr_timer.sv
module noise_clr_timer #(
  parameter int RST_CYCLES = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic test,
  output logic fire
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES);

  logic          test_q, test_q_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          cnt_en;

  always_comb begin
    cnt_nx    = cnt_q;
    fire      = 1'b0;
    test_q_nx = test;
    cnt_en    = 1'b0;
    if (test && !test_q) begin
      cnt_en = 1'b1;
      cnt_nx = LOAD;
    end else if (test && cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_nx = cnt_q - 1'b1;
      fire   = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      test_q <= test_q_nx;
      if (cnt_en) cnt_q <= cnt_nx;
    end
  end

  // R8
  load_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test && !test_q) |=> (cnt_q == LOAD));
  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);
  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!test) |=> $stable(cnt_q));
endmodule

// File: rtl/noise_tap_map.sv
module noise_tap_map
  import noise_lfsr_pkg::*;
(
  input  lfsr_t state,
  input  word_t combo,
  output word_t noise,
  output lfsr_t keep
);
  always_comb begin
    noise = '0;
    keep  = '1;
    for (int i = 0; i < NTAP; i++) begin
      noise[TAP_LSB+i]  = state[tap_pos(i)];
      keep[tap_pos(i)]  = combo[TAP_LSB+i];
    end
  end
endmodule

// File: rtl/noise_lfsr_core.sv
module noise_lfsr_core
  import noise_lfsr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  shift_stb,
  input  logic  test,
  input  logic  wb_en,
  input  logic  fire,
  input  lfsr_t keep,
  output lfsr_t state
);
  lfsr_t state_q, base, state_nx;
  logic  fb;
  logic  upd_en;

  always_comb begin
    base     = wb_en ? (state_q & keep) : state_q;
    fb       = (base[FB_HI] | test) ^ base[FB_LO];
    state_nx = base;
    if (shift_stb && !test) state_nx = {base[LFSR_W-2:0], fb};
    if (fire) state_nx = '1;
    upd_en   = fire | wb_en | (shift_stb & ~test);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= '1;
    else if (upd_en) state_q <= state_nx;
  end

  assign state = state_q;

  // R3
  no_shift_in_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test && !wb_en && !fire) |=> $stable(state_q));
  // R6
  wb_only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !fire && !(shift_stb && !test)) |=> ((state_q & ~$past(state_q)) == '0));
  // R8
  refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (state_q == '1));
  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_stb && !test && !wb_en && !fire) |=>
      (state_q[LFSR_W-1:1] == $past(state_q[LFSR_W-2:0])));
endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen
  import noise_lfsr_pkg::*;
#(
  parameter int RST_CYCLES = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        shift_stb,
  input  logic        test,
  input  logic        wb_en,
  input  logic [11:0] combo_in,
  output logic [11:0] noise_out
);
  logic  fire;
  lfsr_t state, keep;
  word_t noise;

  noise_clr_timer #(.RST_CYCLES(RST_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .test(test), .fire(fire)
  );

  noise_tap_map u_map (
    .state(state), .combo(combo_in), .noise(noise), .keep(keep)
  );

  noise_lfsr_core u_core (
    .clk(clk), .rst_n(rst_n), .shift_stb(shift_stb), .test(test),
    .wb_en(wb_en), .fire(fire), .keep(keep), .state(state)
  );

  assign noise_out = noise;

  // R5
  low_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    noise_out[TAP_LSB-1:0] == '0);
endmodule

// File: tb/tb_noise_lfsr_gen.sv
module tb_noise_lfsr_gen;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shift_stb = 1'b0, test = 1'b0, wb_en = 1'b0;
  logic [11:0] combo_in = '0;
  logic [11:0] noise_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [22:0] m_reg;
  int          m_cnt;
  logic        m_tq;

  noise_lfsr_gen #(.RST_CYCLES(N)) dut (
    .clk(clk), .rst_n(rst_n), .shift_stb(shift_stb), .test(test),
    .wb_en(wb_en), .combo_in(combo_in), .noise_out(noise_out)
  );

  always #5 clk = ~clk;

  // {shift, test, wb, combo}
  localparam logic [14:0] VEC [20] = '{
    {3'b100, 12'h000}, {3'b100, 12'h000}, {3'b100, 12'h000}, {3'b100, 12'h000},
    {3'b100, 12'h000}, {3'b000, 12'h000}, {3'b100, 12'hFFF}, {3'b100, 12'h000},
    {3'b110, 12'h000}, {3'b110, 12'h000}, {3'b000, 12'h000}, {3'b101, 12'hA50},
    {3'b100, 12'h000}, {3'b001, 12'hFFF}, {3'b100, 12'h000}, {3'b100, 12'h000},
    {3'b101, 12'h3C0}, {3'b100, 12'h000}, {3'b001, 12'h000}, {3'b100, 12'h000}
  };

  function automatic logic [11:0] gather(input logic [22:0] s);
    gather = {s[20], s[18], s[14], s[11], s[9], s[5], s[2], s[0], 4'h0};
  endfunction

  function automatic logic [22:0] keepmask(input logic [11:0] c);
    keepmask = '1;
    keepmask[20] = c[11]; keepmask[18] = c[10]; keepmask[14] = c[9];
    keepmask[11] = c[8];  keepmask[9]  = c[7];  keepmask[5]  = c[6];
    keepmask[2]  = c[5];  keepmask[0]  = c[4];
  endfunction

  task automatic check(input string req, input logic [11:0] exp);
    checks++;
    if (noise_out !== exp) begin
      errors++;
      $display("FAIL %s: noise_out=%h expected=%h", req, noise_out, exp);
    end
  endtask

  task automatic step(input logic s, input logic t, input logic w, input logic [11:0] c);
    logic fire;
    logic [22:0] base;
    shift_stb = s; test = t; wb_en = w; combo_in = c;
    @(posedge clk);
    fire = 1'b0;
    if (t && !m_tq) m_cnt = N;
    else if (t && m_cnt != 0) begin
      fire = (m_cnt == 1);
      m_cnt--;
    end
    base = w ? (m_reg & keepmask(c)) : m_reg;
    if (s && !t) base = {base[21:0], (base[22] | t) ^ base[17]};
    m_reg = fire ? '1 : base;
    m_tq = t;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; shift_stb = 0; test = 0; wb_en = 0; combo_in = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_reg = '1; m_cnt = 0; m_tq = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: expired, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1", 12'hFF0);

    // table walk against requirement model (R2 R4 R5 R6 R7 R3)
    for (int i = 0; i < 20; i++) begin
      step(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:0]);
      check("R4 table", gather(m_reg));
      checks++;
      if (noise_out[3:0] !== 4'h0) begin
        errors++;
        $display("FAIL R5: low=%h expected=0", noise_out[3:0]);
      end
    end

    // R2: single shift from all ones
    do_reset();
    step(1, 0, 0, 12'h000);
    check("R2", 12'hFE0);

    // R3: test high blocks shifting
    step(1, 1, 0, 12'h000);
    step(1, 1, 0, 12'h000);
    check("R3", 12'hFE0);
    step(0, 0, 0, 12'h000);

    // R7: combo ignored without wb_en
    do_reset();
    step(0, 0, 0, 12'h000);
    check("R7", 12'hFF0);

    // R6: clear then cannot set back
    step(0, 0, 1, 12'h000);
    check("R6 clear", 12'h000);
    step(0, 0, 1, 12'hFFF);
    check("R6 sticky", 12'h000);

    // R8: countdown expiry exactly at N edges after load
    for (int k = 1; k <= N; k++) step(0, 1, 0, 12'h000);
    check("R8 before expiry", 12'h000);
    step(0, 1, 0, 12'h000);
    check("R8 expiry", 12'hFF0);
    step(0, 0, 0, 12'h000);

    // R9: interrupted hold then full reload
    step(0, 0, 1, 12'h000);
    for (int k = 0; k < 5; k++) step(0, 1, 0, 12'h000);
    step(0, 0, 0, 12'h000);
    check("R9 no refill on drop", 12'h000);
    for (int k = 0; k < N; k++) step(0, 1, 0, 12'h000);
    check("R9 reload full", 12'h000);
    step(0, 1, 0, 12'h000);
    check("R9 refill", 12'hFF0);
    step(0, 0, 0, 12'h000);

    // R10: refill beats writeback
    step(0, 0, 1, 12'h000);
    for (int k = 0; k < N; k++) step(0, 1, 0, 12'h000);
    step(0, 1, 1, 12'h000);
    check("R10 refill over wb", 12'hFF0);
    step(0, 0, 0, 12'h000);

    // R10: writeback before shift in one cycle
    do_reset();
    step(1, 0, 1, 12'h000);
    check("R10 wb then shift", 12'hFE0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule